// File: doc/BRIEF.md
# Four-Channel Converter Register Front End

This block is the register front end of a four-channel, 12-bit converter. A host drives a 12-bit parallel word, a 2-bit channel select and three active-low controls: a chip select, a mode select and a load strobe. All of these are brought into the clock domain, and the register actions are taken from the edges seen there. Each channel has an input rank and an output rank for its code. A shared 8-bit mode word, also held in an input rank and an output rank, gives each channel a gain bit and a polarity bit.

A falling chip select captures the bus into an input rank. Mode select low routes the capture to the mode word, and mode select high routes it to the selected channel's code. A rising load strobe copies an input rank into its output rank. Used together, the two controls load and update in one cycle. Used apart, they preload a value and commit it later. Two transparent controls bypass the input rank: one drives the selected channel's output rank from the bus, and the other drives all four.

Top module: `quad_dac_regs`

## Requirements
- R1: After the asynchronous reset, every channel code is 0, every gain bit is 0 (span of 1x reference) and every polarity bit is 0 (unipolar).
- R2: A falling chip select with mode select high stores busIn into the input rank of the channel chosen by chanSel. No output changes.
- R3: A rising load strobe with mode select high copies the chosen channel's input rank into its output code (codeOut[12*i +: 12] is channel i). The other channels hold their codes.
- R4: A falling chip select with mode select low stores busIn[11:4] into the mode input rank and ignores busIn[3:0]. gainOut and bipolarOut do not change.
- R5: A rising load strobe with mode select low copies the mode input rank to the outputs. gainOut[i] comes from bus bit 8+i, where 1 means a 2x span. bipolarOut[i] comes from bus bit 4+i, where 1 means bipolar.
- R6: Load and update works for both modes and codes. With the load strobe low, a falling chip select followed by a rising load strobe puts the new word on the outputs.
- R7: When a chip select fall and a load strobe rise are first seen in the same clock, the output rank receives the word captured in that clock.
- R8: While passOne is high, the output code of the channel chosen by chanSel follows busIn. The other channels hold their codes, and no input rank changes.
- R9: While passAll is high, all four output codes follow busIn. The mode outputs and the input ranks do not change.
- R10: An output driven by a control edge changes on the third rising clock edge after that control edge is applied.
- R11: Bus, chanSel and mode select activity without a load strobe edge or a transparent control leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busIn | input | 12 | Parallel data and mode word |
| csN | input | 1 | Chip select, active low; falling edge captures |
| msN | input | 1 | Mode select, active low; low targets the mode word |
| lsN | input | 1 | Load strobe, active low; rising edge commits |
| chanSel | input | 2 | Channel select |
| passOne | input | 1 | Transparent path for the selected channel |
| passAll | input | 1 | Transparent path for all channels |
| codeOut | output | 48 | Output codes; channel i at bits 12*i+11 down to 12*i |
| gainOut | output | 4 | Gain per channel, 1 = 2x span |
| bipolarOut | output | 4 | Polarity per channel, 1 = bipolar |

## Verification
The capture on a chip select fall and the commit on a load strobe rise can land in the same clock. The bench provokes this by driving both edges at one falling clock edge, after leaving the input rank of channel 0 holding an older value. The result is correct only if the output shows the freshly captured word and not the older one. Transparency against a pending commit is also watched, because the transparent write takes priority on the channel it drives.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int CH_NUM = 4;
  localparam int CODE_W = 12;
  localparam int ADDR_W = $clog2(CH_NUM);
  localparam int MODE_W = 2 * CH_NUM;

  typedef struct packed {
    logic                capture;  // chip select fall seen
    logic                commit;   // load strobe rise seen
    logic                modeSel;  // mode word targeted
    logic                passOne;
    logic                passAll;
    logic [ADDR_W-1:0]   chan;
    logic [CODE_W-1:0]   word;
  } strobe_t;
endpackage

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import quad_dac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] busIn,
  input  logic              csN,
  input  logic              msN,
  input  logic              lsN,
  input  logic [ADDR_W-1:0] chanSel,
  input  logic              passOne,
  input  logic              passAll,
  output strobe_t           strobes
);
  localparam int SYNC_W  = CODE_W + ADDR_W + 5;
  localparam int ADDR_LO = CODE_W;
  localparam int PALL_B  = CODE_W + ADDR_W;
  localparam int PONE_B  = PALL_B + 1;
  localparam int LS_B    = PALL_B + 2;
  localparam int MS_B    = PALL_B + 3;
  localparam int CS_B    = PALL_B + 4;
  localparam logic [SYNC_W-1:0] IDLE = {3'b111, {(SYNC_W-3){1'b0}}};

  logic [SYNC_STAGES-1:0][SYNC_W-1:0] stage;
  logic [SYNC_W-1:0] rawIn, cur;
  logic prevCs, prevLs;

  assign rawIn = {csN, msN, lsN, passOne, passAll, chanSel, busIn};
  assign cur   = stage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= IDLE;
      prevCs <= 1'b1;
      prevLs <= 1'b1;
    end else begin
      stage[0] <= rawIn;
      for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
      prevCs <= cur[CS_B];
      prevLs <= cur[LS_B];
    end
  end

  always_comb begin
    strobes.capture = prevCs & ~cur[CS_B];
    strobes.commit  = ~prevLs & cur[LS_B];
    strobes.modeSel = ~cur[MS_B];
    strobes.passOne = cur[PONE_B];
    strobes.passAll = cur[PALL_B];
    strobes.chan    = cur[ADDR_LO +: ADDR_W];
    strobes.word    = cur[CODE_W-1:0];
  end
endmodule

// File: rtl/quad_dac_datapath.sv
module quad_dac_datapath
  import quad_dac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobes,
  output logic [CH_NUM*CODE_W-1:0] codeOut,
  output logic [CH_NUM-1:0]        gainOut,
  output logic [CH_NUM-1:0]        bipolarOut
);
  logic [MODE_W-1:0] modeFirst, modeSecond, modeField;

  assign modeField = strobes.word[CODE_W-1 -: MODE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeFirst  <= '0;
      modeSecond <= '0;
    end else if (strobes.modeSel) begin
      if (strobes.capture) modeFirst <= modeField;
      if (strobes.commit)
        modeSecond <= strobes.capture ? modeField : modeFirst;
    end
  end

  assign gainOut    = modeSecond[MODE_W-1 -: CH_NUM];
  assign bipolarOut = modeSecond[CH_NUM-1:0];

  for (genvar g = 0; g < CH_NUM; g++) begin : g_chan
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
    logic [CODE_W-1:0] dataFirst, dataSecond;
    logic hit, dataWr;

    assign hit    = (strobes.chan == IDX);
    assign dataWr = hit & ~strobes.modeSel;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataFirst  <= '0;
        dataSecond <= '0;
      end else begin
        if (dataWr && strobes.capture) dataFirst <= strobes.word;
        if (dataWr && strobes.commit)
          dataSecond <= strobes.capture ? strobes.word : dataFirst;
        if (strobes.passAll || (strobes.passOne && hit))
          dataSecond <= strobes.word;
      end
    end

    assign codeOut[g*CODE_W +: CODE_W] = dataSecond;
  end
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
  import quad_dac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CODE_W-1:0]        busIn,
  input  logic                     csN,
  input  logic                     msN,
  input  logic                     lsN,
  input  logic [ADDR_W-1:0]        chanSel,
  input  logic                     passOne,
  input  logic                     passAll,
  output logic [CH_NUM*CODE_W-1:0] codeOut,
  output logic [CH_NUM-1:0]        gainOut,
  output logic [CH_NUM-1:0]        bipolarOut
);
  strobe_t strobes;

  quad_dac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .busIn(busIn), .csN(csN), .msN(msN),
    .lsN(lsN), .chanSel(chanSel), .passOne(passOne), .passAll(passAll),
    .strobes(strobes)
  );

  quad_dac_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .codeOut(codeOut), .gainOut(gainOut), .bipolarOut(bipolarOut)
  );
endmodule

// File: rtl/quad_dac_regs_chk.sv
module quad_dac_regs_chk
  import quad_dac_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [CODE_W-1:0]        busIn,
  input logic                     lsN,
  input logic [ADDR_W-1:0]        chanSel,
  input logic                     passOne,
  input logic                     passAll,
  input logic [CH_NUM*CODE_W-1:0] codeOut,
  input logic [CH_NUM-1:0]        gainOut,
  input logic [CH_NUM-1:0]        bipolarOut
);
  logic              lsPrev;
  logic [CODE_W-1:0] busPrev;
  logic [ADDR_W-1:0] chanPrev;
  logic [1:0]        lsQuiet, dataQuiet, allCnt, oneCnt;
  logic              allMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsPrev    <= 1'b1;
      busPrev   <= '0;
      chanPrev  <= '0;
      lsQuiet   <= '0;
      dataQuiet <= '0;
      allCnt    <= '0;
      oneCnt    <= '0;
    end else begin
      lsPrev   <= lsN;
      busPrev  <= busIn;
      chanPrev <= chanSel;
      lsQuiet  <= (lsN != lsPrev) ? 2'd0 : (lsQuiet == 2'd3 ? 2'd3 : lsQuiet + 2'd1);
      dataQuiet <= ((lsN != lsPrev) || passOne || passAll) ? 2'd0
                 : (dataQuiet == 2'd3 ? 2'd3 : dataQuiet + 2'd1);
      allCnt <= (passAll && busIn == busPrev)
                ? (allCnt == 2'd3 ? 2'd3 : allCnt + 2'd1) : 2'd0;
      oneCnt <= (passOne && !passAll && busIn == busPrev && chanSel == chanPrev)
                ? (oneCnt == 2'd3 ? 2'd3 : oneCnt + 2'd1) : 2'd0;
    end
  end

  always_comb begin
    allMatch = 1'b1;
    for (int i = 0; i < CH_NUM; i++)
      if (codeOut[i*CODE_W +: CODE_W] != busIn) allMatch = 1'b0;
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    lsQuiet == 2'd3 |-> $stable({gainOut, bipolarOut})); // R11

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    dataQuiet == 2'd3 |-> $stable(codeOut)); // R11

  AST_ALL_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    allCnt == 2'd3 |-> allMatch); // R9

  AST_ONE_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    oneCnt == 2'd3 |-> codeOut[chanSel*CODE_W +: CODE_W] == busIn); // R8
endmodule

bind quad_dac_regs quad_dac_regs_chk chk_i (
  .clk(clk), .rstN(rstN), .busIn(busIn), .lsN(lsN), .chanSel(chanSel),
  .passOne(passOne), .passAll(passAll), .codeOut(codeOut),
  .gainOut(gainOut), .bipolarOut(bipolarOut)
);

// File: tb/quad_dac_regs_test.sv
`timescale 1ns/1ps
module quad_dac_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busIn = '0;
  logic        csN = 1'b1, msN = 1'b1, lsN = 1'b1;
  logic [1:0]  chanSel = '0;
  logic        passOne = 1'b0, passAll = 1'b0;
  logic [47:0] codeOut;
  logic [3:0]  gainOut, bipolarOut;

  int checks = 0;
  int errors = 0;
  logic [11:0] expCode [4];
  logic [3:0]  expGain = '0, expBip = '0;

  always #5 clk = ~clk;

  quad_dac_regs uut (
    .clk(clk), .rstN(rstN), .busIn(busIn), .csN(csN), .msN(msN), .lsN(lsN),
    .chanSel(chanSel), .passOne(passOne), .passAll(passAll),
    .codeOut(codeOut), .gainOut(gainOut), .bipolarOut(bipolarOut)
  );

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkVal(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    checkVal(req, codeOut, {expCode[3], expCode[2], expCode[1], expCode[0]});
    checkVal(req, {40'd0, gainOut, bipolarOut}, {40'd0, expGain, expBip});
  endtask

  task automatic preloadCode(logic [1:0] ch, logic [11:0] val);
    msN = 1'b1; chanSel = ch; busIn = val; csN = 1'b0;
    settle();
    csN = 1'b1;
    settle();
  endtask

  task automatic commitCode(logic [1:0] ch);
    msN = 1'b1; chanSel = ch; lsN = 1'b0;
    settle();
    lsN = 1'b1;
    settle();
  endtask

  task automatic testReset();
    checkAll("R1 reset state");
  endtask

  task automatic testPreloadCommit();
    preloadCode(2'd1, 12'hABC);
    checkAll("R2 preload leaves outputs");
    commitCode(2'd1);
    expCode[1] = 12'hABC;
    checkAll("R3 commit channel 1 only");
  endtask

  task automatic testLatency();
    preloadCode(2'd2, 12'h123);
    msN = 1'b1; chanSel = 2'd2; lsN = 1'b0;
    settle();
    lsN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkAll("R10 no change after two edges");
    @(posedge clk);
    @(negedge clk);
    expCode[2] = 12'h123;
    checkAll("R10 change on third edge");
  endtask

  task automatic testModePreload();
    msN = 1'b0; busIn = 12'hA5F; csN = 1'b0;
    settle();
    csN = 1'b1; msN = 1'b1;
    settle();
    checkAll("R4 mode preload leaves outputs");
    msN = 1'b0; lsN = 1'b0;
    settle();
    lsN = 1'b1;
    settle();
    msN = 1'b1;
    expGain = 4'b1010; expBip = 4'b0101;
    checkAll("R5 mode commit bit mapping");
  endtask

  task automatic testIdle();
    msN = 1'b0; chanSel = 2'd3; busIn = 12'h0F0;
    settle();
    msN = 1'b1; busIn = 12'h777; chanSel = 2'd0;
    settle();
    checkAll("R11 idle activity ignored");
  endtask

  task automatic testLoadUpdate();
    msN = 1'b0; lsN = 1'b0;
    settle();
    busIn = 12'h3C0; csN = 1'b0;
    settle();
    checkAll("R6 mode captured not yet shown");
    lsN = 1'b1;
    settle();
    expGain = 4'b0011; expBip = 4'b1100;
    checkAll("R6 mode load and update");
    csN = 1'b1; msN = 1'b1;
    settle();
    chanSel = 2'd3; lsN = 1'b0;
    settle();
    busIn = 12'h7E1; csN = 1'b0;
    settle();
    lsN = 1'b1;
    settle();
    csN = 1'b1;
    settle();
    expCode[3] = 12'h7E1;
    checkAll("R6 data load and update");
  endtask

  task automatic testCoincide();
    msN = 1'b1; chanSel = 2'd0; lsN = 1'b0;
    settle();
    busIn = 12'h5A5; csN = 1'b0; lsN = 1'b1;
    settle();
    csN = 1'b1;
    settle();
    expCode[0] = 12'h5A5;
    checkAll("R7 same-cycle capture and commit");
  endtask

  task automatic testPassOne();
    chanSel = 2'd2; busIn = 12'h999; passOne = 1'b1;
    settle();
    expCode[2] = 12'h999;
    checkAll("R8 selected channel follows bus");
    busIn = 12'h666;
    settle();
    expCode[2] = 12'h666;
    checkAll("R8 follows bus change");
    passOne = 1'b0;
    settle();
    checkAll("R8 holds after release");
    commitCode(2'd2);
    expCode[2] = 12'h123;
    checkAll("R8 input rank untouched");
  endtask

  task automatic testPassAll();
    busIn = 12'hF0F; passAll = 1'b1;
    settle();
    for (int i = 0; i < 4; i++) expCode[i] = 12'hF0F;
    checkAll("R9 all channels follow bus");
    passAll = 1'b0;
    settle();
    commitCode(2'd1);
    expCode[1] = 12'hABC;
    checkAll("R9 input ranks untouched");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) expCode[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    testReset();
    testPreloadCommit();
    testLatency();
    testModePreload();
    testIdle();
    testLoadUpdate();
    testCoincide();
    testPassOne();
    testPassAll();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule